// File: doc/BRIEF.md
# Precise Exception Capture Unit

This block sits at the commit point of an in-order pipeline that retires a group of up to `NSLOT` instructions per cycle. Slot 0 holds the oldest instruction. Each slot comes with its address, a flag that marks it as sitting in a branch delay slot, an exception request with a 5-bit reason code, and the side effects it would have if it retired: register writeback, store, and base-address increment. The unit chooses the oldest cause of a trap. It lets every older instruction in the group retire. It gates off all side effects of the faulting instruction and of every younger one. In the same cycle it sends fetch to a fixed handler address.

The unit keeps two registers. The exception PC holds the faulting address, or the address of the branch when the faulting instruction sits in a delay slot. The cause register holds the reason code and the delay-slot flag. Multiply and divide operations never trap. A scoreboard of result registers still owed by the long-latency unit holds back any commit group that reads one of them. A long operation stays in flight across a trap.

A return-from-exception pulse sends fetch back to the saved exception PC.

Top module: `exc_commit_unit`

## Requirements
- R1: After synchronous reset, the exception PC and cause register read zero, the scoreboard is empty, and `stall_o` and `redirect_o` are low.
- R2: When a slot traps, the next clock edge loads its address into `epc_o`. The same edge loads its reason code into `cause_o[6:2]`, and all other cause bits become zero except bit 31.
- R3: When the trapping slot has its delay flag set, `epc_o` receives its address minus 4 and `cause_o[31]` is set. Otherwise bit 31 is cleared.
- R4: The trapping slot and every valid younger slot have `kill_o` high and their writeback, store and increment enables low.
- R5: Valid slots older than the trapping slot retire with their requested side effects enabled.
- R6: When several slots request exceptions in the same cycle, only the oldest one (lowest index) is reported.
- R7: In a trap cycle, `redirect_o` and `flush_young_o` are high and `redirect_pc_o` equals `HANDLER_PC` (default 32'h0000_0400).
- R8: An exception request on a slot marked as multiply/divide is ignored. The slot retires, `md_go_o` rises for it, and `epc_o` and `cause_o` are unchanged.
- R9: When any valid slot reads (rs or rt) a register owed by an in-flight multiply/divide, `stall_o` is high. That cycle retires nothing, takes no trap and starts no multiply/divide. The stall ends once `md_done_i` has returned that register. Register 0 is never owed.
- R10: A trap does not cancel an in-flight multiply/divide. Its destination stays owed until `md_done_i` returns it.
- R11: An interrupt is taken only when slot 0 is valid and the group is not stalled. It uses reason code 0, kills slot 0 and all younger slots, and saves slot 0's address, following the R3 delay-slot rule.
- R12: Outside a trap, `epc_o` and `cause_o` hold their values. `sw_clr_i` clears both to zero. A trap in the same cycle takes priority over the clear.
- R13: `eret_i` without a trap raises `redirect_o` with `redirect_pc_o` equal to `epc_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_vld_i | input | NSLOT | Slot holds an instruction at commit |
| slot_pc_i | input | NSLOT*32 | Slot addresses, slot i at [i*32 +: 32] |
| slot_bd_i | input | NSLOT | Slot sits in a branch delay slot |
| slot_exc_i | input | NSLOT | Slot requests an exception |
| slot_code_i | input | NSLOT*5 | Reason codes, slot i at [i*5 +: 5] |
| slot_md_i | input | NSLOT | Slot is a multiply/divide |
| slot_we_i | input | NSLOT | Slot wants register writeback |
| slot_st_i | input | NSLOT | Slot wants a store |
| slot_inc_i | input | NSLOT | Slot wants base-address increment |
| slot_rs_i | input | NSLOT*RIDX | First source register per slot |
| slot_rt_i | input | NSLOT*RIDX | Second source register per slot |
| slot_rd_i | input | NSLOT*RIDX | Destination register per slot |
| irq_i | input | 1 | External interrupt request |
| md_done_i | input | 1 | Multiply/divide result returned |
| md_done_rd_i | input | RIDX | Register that result is for |
| sw_clr_i | input | 1 | Software clear of exception PC and cause |
| eret_i | input | 1 | Return from exception |
| stall_o | output | 1 | Commit group held for an owed register |
| wb_en_o | output | NSLOT | Writeback enable per slot |
| st_en_o | output | NSLOT | Store enable per slot |
| inc_en_o | output | NSLOT | Increment enable per slot |
| md_go_o | output | NSLOT | Multiply/divide started per slot |
| kill_o | output | NSLOT | Slot squashed |
| flush_young_o | output | 1 | Flush stages behind commit |
| redirect_o | output | 1 | Fetch redirect |
| redirect_pc_o | output | 32 | Redirect target |
| epc_o | output | 32 | Exception PC |
| cause_o | output | 32 | Cause register |

## Verification
Some properties are checked on every cycle. Killed slots never carry a side effect. Kills run from the trap point through all younger valid slots. A stalled group neither retires nor traps. A trap always points fetch at the handler. Owed registers stay owed until their result returns. The exception PC and cause hold their values outside traps and clears, and a delay-slot trap always lands on the branch address with bit 31 set.

The bench's scenarios cover the rest. These are the exact reason code saved, the choice of the oldest of simultaneous faults, masked multiply/divide requests, interrupt gating on a valid slot 0, priority of a trap over a clear, and the release of a stall after the long result returns.

// File: rtl/ecu_pkg.sv
// Shared constants and types for the exception capture unit.
// Assumes 32-bit addresses and a 5-bit reason code.
package ecu_pkg;
    localparam int XLEN      = 32;
    localparam int CODE_W    = 5;
    localparam int CODE_LSB  = 2;
    localparam int BD_BIT    = 31;
    localparam logic [CODE_W-1:0] IRQ_CODE = 5'd0;

    typedef struct packed {
        logic              take;
        logic [XLEN-1:0]   pc;
        logic              bd;
        logic [CODE_W-1:0] code;
    } trap_t;
endpackage

// File: rtl/ecu_scoreboard.sv
// Tracks destination registers owed by the long-latency multiply/divide
// unit. It raises a stall when any valid commit slot reads an owed register.
// Assumes upstream logic separates same-group reads of a multiply/divide
// destination. Register 0 is never tracked.
module ecu_scoreboard #(
    parameter int NSLOT = 2,
    parameter int NREG  = 32,
    localparam int RIDX = $clog2(NREG)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NSLOT-1:0]      vld_i,
    input  logic [NSLOT*RIDX-1:0] rs_i,
    input  logic [NSLOT*RIDX-1:0] rt_i,
    input  logic [NSLOT*RIDX-1:0] rd_i,
    input  logic [NSLOT-1:0]      md_go_i,
    input  logic                  done_i,
    input  logic [RIDX-1:0]       done_rd_i,
    output logic                  stall_o
);
    logic [NREG-1:0] busy_q, set_m, clr_m;

    // Hazard detection: any valid slot reading an owed register.
    always_comb begin
        stall_o = 1'b0;
        for (int i = 0; i < NSLOT; i++) begin
            if (vld_i[i] && (busy_q[rs_i[i*RIDX +: RIDX]] || busy_q[rt_i[i*RIDX +: RIDX]]))
                stall_o = 1'b1;
        end
    end

    // Set and clear masks from issuing slots and the returning result.
    always_comb begin
        set_m = '0;
        clr_m = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (md_go_i[i] && (rd_i[i*RIDX +: RIDX] != '0))
                set_m[rd_i[i*RIDX +: RIDX]] = 1'b1;
        end
        if (done_i)
            clr_m[done_rd_i] = 1'b1;
    end

    // Owed-register state; a new issue wins over a same-cycle return.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= '0;
        else        busy_q <= (busy_q & ~clr_m) | set_m;
    end

    // R10: without a returning result, no owed register is released.
    a_r10_owed_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> ((busy_q & $past(busy_q)) == $past(busy_q)));

    // R1/R9: register 0 is never owed.
    a_r9_zero_free: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q[0]);
endmodule

// File: rtl/ecu_arbiter.sv
// Picks the oldest trap cause in the commit group and builds the kill and
// retire masks. An interrupt ranks ahead of slot 0. Multiply/divide requests
// are masked. Nothing traps while the group is stalled.
module ecu_arbiter
    import ecu_pkg::*;
#(
    parameter int NSLOT = 2
) (
    input  logic [NSLOT-1:0]        vld_i,
    input  logic [NSLOT-1:0]        exc_i,
    input  logic [NSLOT-1:0]        md_i,
    input  logic [NSLOT-1:0]        bd_i,
    input  logic [NSLOT*XLEN-1:0]   pc_i,
    input  logic [NSLOT*CODE_W-1:0] code_i,
    input  logic                    irq_i,
    input  logic                    stall_i,
    output trap_t                   trap_o,
    output logic [NSLOT-1:0]        kill_o,
    output logic [NSLOT-1:0]        commit_o
);
    logic found;

    // Age-ordered scan: first hit is reported, it and everything after are killed.
    always_comb begin
        found       = irq_i && vld_i[0] && !stall_i;
        trap_o.pc   = pc_i[0 +: XLEN];
        trap_o.bd   = bd_i[0];
        trap_o.code = IRQ_CODE;
        for (int i = 0; i < NSLOT; i++) begin
            if (!found && !stall_i && vld_i[i] && exc_i[i] && !md_i[i]) begin
                found       = 1'b1;
                trap_o.pc   = pc_i[i*XLEN +: XLEN];
                trap_o.bd   = bd_i[i];
                trap_o.code = code_i[i*CODE_W +: CODE_W];
            end
            kill_o[i]   = found && vld_i[i];
            commit_o[i] = vld_i[i] && !stall_i && !kill_o[i];
        end
        trap_o.take = found;
    end
endmodule

// File: rtl/ecu_state_regs.sv
// Holds the exception PC and cause register. Both load on a trap and clear
// on a software clear; a trap wins over a clear in the same cycle.
module ecu_state_regs
    import ecu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  trap_t           trap_i,
    input  logic            sw_clr_i,
    output logic [XLEN-1:0] epc_o,
    output logic [XLEN-1:0] cause_o
);
    logic [XLEN-1:0] cause_d;

    // Cause word: reason code field plus delay-slot flag.
    always_comb begin
        cause_d = '0;
        cause_d[CODE_LSB +: CODE_W] = trap_i.code;
        cause_d[BD_BIT]             = trap_i.bd;
    end

    // Capture on trap, clear on software request, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc_o   <= '0;
            cause_o <= '0;
        end else if (trap_i.take) begin
            epc_o   <= trap_i.bd ? trap_i.pc - XLEN'(4) : trap_i.pc;
            cause_o <= cause_d;
        end else if (sw_clr_i) begin
            epc_o   <= '0;
            cause_o <= '0;
        end
    end

    // R12: hold outside a trap or clear.
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_i.take && !sw_clr_i |=> $stable(epc_o) && $stable(cause_o));

    // R3: a delay-slot trap lands on the branch address with the flag set.
    a_r3_branch_epc: assert property (@(posedge clk) disable iff (!rst_n)
        trap_i.take && trap_i.bd |=> cause_o[BD_BIT] && (epc_o + XLEN'(4) == $past(trap_i.pc)));

    // R2: a plain trap saves its own address.
    a_r2_own_epc: assert property (@(posedge clk) disable iff (!rst_n)
        trap_i.take && !trap_i.bd |=> !cause_o[BD_BIT] && (epc_o == $past(trap_i.pc)));
endmodule

// File: rtl/exc_commit_unit.sv
// Top of the precise exception capture unit at the commit stage.
// Combines the scoreboard, the age-ordered arbiter and the saved state.
// Gates the side effects of each slot and drives the fetch redirect.
// Assumes slot 0 is the oldest instruction in the commit group.
module exc_commit_unit
    import ecu_pkg::*;
#(
    parameter int NSLOT = 2,
    parameter int NREG  = 32,
    parameter logic [31:0] HANDLER_PC = 32'h0000_0400,
    localparam int RIDX = $clog2(NREG)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NSLOT-1:0]        slot_vld_i,
    input  logic [NSLOT*32-1:0]     slot_pc_i,
    input  logic [NSLOT-1:0]        slot_bd_i,
    input  logic [NSLOT-1:0]        slot_exc_i,
    input  logic [NSLOT*5-1:0]      slot_code_i,
    input  logic [NSLOT-1:0]        slot_md_i,
    input  logic [NSLOT-1:0]        slot_we_i,
    input  logic [NSLOT-1:0]        slot_st_i,
    input  logic [NSLOT-1:0]        slot_inc_i,
    input  logic [NSLOT*RIDX-1:0]   slot_rs_i,
    input  logic [NSLOT*RIDX-1:0]   slot_rt_i,
    input  logic [NSLOT*RIDX-1:0]   slot_rd_i,
    input  logic                    irq_i,
    input  logic                    md_done_i,
    input  logic [RIDX-1:0]         md_done_rd_i,
    input  logic                    sw_clr_i,
    input  logic                    eret_i,
    output logic                    stall_o,
    output logic [NSLOT-1:0]        wb_en_o,
    output logic [NSLOT-1:0]        st_en_o,
    output logic [NSLOT-1:0]        inc_en_o,
    output logic [NSLOT-1:0]        md_go_o,
    output logic [NSLOT-1:0]        kill_o,
    output logic                    flush_young_o,
    output logic                    redirect_o,
    output logic [31:0]             redirect_pc_o,
    output logic [31:0]             epc_o,
    output logic [31:0]             cause_o
);
    trap_t            trap;
    logic [NSLOT-1:0] commit;

    ecu_scoreboard #(.NSLOT(NSLOT), .NREG(NREG)) u_sb (
        .clk(clk), .rst_n(rst_n), .vld_i(slot_vld_i),
        .rs_i(slot_rs_i), .rt_i(slot_rt_i), .rd_i(slot_rd_i),
        .md_go_i(md_go_o), .done_i(md_done_i), .done_rd_i(md_done_rd_i),
        .stall_o(stall_o)
    );

    ecu_arbiter #(.NSLOT(NSLOT)) u_arb (
        .vld_i(slot_vld_i), .exc_i(slot_exc_i), .md_i(slot_md_i), .bd_i(slot_bd_i),
        .pc_i(slot_pc_i), .code_i(slot_code_i), .irq_i(irq_i), .stall_i(stall_o),
        .trap_o(trap), .kill_o(kill_o), .commit_o(commit)
    );

    ecu_state_regs u_regs (
        .clk(clk), .rst_n(rst_n), .trap_i(trap), .sw_clr_i(sw_clr_i),
        .epc_o(epc_o), .cause_o(cause_o)
    );

    // Side effects allowed only for retiring slots.
    always_comb begin
        wb_en_o  = commit & slot_we_i;
        st_en_o  = commit & slot_st_i;
        inc_en_o = commit & slot_inc_i;
        md_go_o  = commit & slot_md_i;
    end

    // Fetch redirect: handler on a trap, saved PC on a return.
    always_comb begin
        flush_young_o = trap.take;
        redirect_o    = trap.take || eret_i;
        redirect_pc_o = trap.take ? HANDLER_PC : epc_o;
    end

    // R4: killed slots never carry a side effect.
    a_r4_killed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((kill_o & (wb_en_o | st_en_o | inc_en_o | md_go_o)) == '0));

    // R9: a stalled group neither retires nor traps.
    a_r9_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> (wb_en_o == '0) && (st_en_o == '0) && (md_go_o == '0) && !flush_young_o);

    // R7: a trap always points fetch at the handler.
    a_r7_handler: assert property (@(posedge clk) disable iff (!rst_n)
        flush_young_o |-> redirect_o && (redirect_pc_o == HANDLER_PC));

    // R5: kills run from the trap point through all younger valid slots.
    for (genvar g = 0; g + 1 < NSLOT; g++) begin : g_order
        a_r5_age_order: assert property (@(posedge clk) disable iff (!rst_n)
            kill_o[g] && slot_vld_i[g+1] |-> kill_o[g+1]);
    end
endmodule

// File: tb/tb_exc_commit_unit.sv
module tb_exc_commit_unit;
    localparam int NS = 2;
    localparam int RI = 5;
    localparam logic [31:0] VEC = 32'h0000_0400;

    logic clk = 1'b0;
    logic rst_n;
    logic [NS-1:0] vld, bd, exc, md, we, st, inc;
    logic [NS*32-1:0] pc;
    logic [NS*5-1:0] code;
    logic [NS*RI-1:0] rs, rt, rd;
    logic irq, mdone, sw_clr, eret;
    logic [RI-1:0] mdone_rd;
    logic stall, flush, redirect;
    logic [NS-1:0] wb_en, st_en, inc_en, md_go, kill;
    logic [31:0] rpc, epc, cause;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    exc_commit_unit #(.NSLOT(NS), .NREG(32), .HANDLER_PC(VEC)) dut (
        .clk(clk), .rst_n(rst_n), .slot_vld_i(vld), .slot_pc_i(pc), .slot_bd_i(bd),
        .slot_exc_i(exc), .slot_code_i(code), .slot_md_i(md), .slot_we_i(we),
        .slot_st_i(st), .slot_inc_i(inc), .slot_rs_i(rs), .slot_rt_i(rt), .slot_rd_i(rd),
        .irq_i(irq), .md_done_i(mdone), .md_done_rd_i(mdone_rd), .sw_clr_i(sw_clr),
        .eret_i(eret), .stall_o(stall), .wb_en_o(wb_en), .st_en_o(st_en),
        .inc_en_o(inc_en), .md_go_o(md_go), .kill_o(kill), .flush_young_o(flush),
        .redirect_o(redirect), .redirect_pc_o(rpc), .epc_o(epc), .cause_o(cause)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        vld = '0; bd = '0; exc = '0; md = '0; we = '0; st = '0; inc = '0;
        pc = '0; code = '0; rs = '0; rt = '0; rd = '0;
        irq = 0; mdone = 0; mdone_rd = '0; sw_clr = 0; eret = 0;
    endtask

    task automatic slot(input int s, input logic [31:0] a, input logic d, input logic e,
                        input logic [4:0] c, input logic m, input logic [4:0] r1,
                        input logic [4:0] r2, input logic [4:0] dst);
        vld[s] = 1; pc[s*32 +: 32] = a; bd[s] = d; exc[s] = e; code[s*5 +: 5] = c;
        md[s] = m; we[s] = !m; st[s] = 1; inc[s] = 1;
        rs[s*RI +: RI] = r1; rt[s*RI +: RI] = r2; rd[s*RI +: RI] = dst;
    endtask

    // Wait to the next edge, then release inputs one step later.
    task automatic step();
        @(posedge clk); #1; idle();
    endtask

    task automatic t_reset();
        idle(); rst_n = 0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk("R1 epc", epc, 0); chk("R1 cause", cause, 0);
        chk("R1 stall", 32'(stall), 0); chk("R1 redirect", 32'(redirect), 0);
    endtask

    task automatic t_clean_group();
        slot(0, 32'h80, 0, 0, 0, 0, 1, 2, 4); slot(1, 32'h84, 0, 0, 0, 0, 1, 2, 5);
        @(negedge clk);
        chk("R5 wb both", 32'(wb_en), 3); chk("R5 st both", 32'(st_en), 3);
        chk("R7 no redirect", 32'(redirect), 0);
        step();
    endtask

    task automatic t_young_fault();
        slot(0, 32'h100, 0, 0, 0, 0, 1, 2, 4); slot(1, 32'h104, 0, 1, 5'd5, 0, 1, 2, 5);
        @(negedge clk);
        chk("R5 older retires", 32'(wb_en), 1); chk("R4 kill", 32'(kill), 2);
        chk("R4 inc", 32'(inc_en), 1);
        chk("R7 redirect", 32'(redirect), 1); chk("R7 vector", rpc, VEC);
        chk("R7 flush", 32'(flush), 1);
        step(); #1;
        chk("R2 epc", epc, 32'h104); chk("R2 cause", cause, 32'(5) << 2);
    endtask

    task automatic t_both_fault();
        slot(0, 32'h200, 0, 1, 5'd4, 0, 1, 2, 4); slot(1, 32'h204, 0, 1, 5'd7, 0, 1, 2, 5);
        @(negedge clk);
        chk("R6 kill all", 32'(kill), 3); chk("R4 no wb", 32'(wb_en), 0);
        chk("R4 no store", 32'(st_en), 0);
        step(); #1;
        chk("R6 epc oldest", epc, 32'h200); chk("R6 cause oldest", cause, 32'(4) << 2);
    endtask

    task automatic t_delay_slot();
        slot(0, 32'h208, 1, 1, 5'd9, 0, 1, 2, 4);
        step(); #1;
        chk("R3 epc branch", epc, 32'h204); chk("R3 cause bd", cause, 32'h8000_0000 | (32'(9) << 2));
        step(); #1;
        chk("R12 epc held", epc, 32'h204); chk("R12 cause held", cause, 32'h8000_0000 | (32'(9) << 2));
    endtask

    task automatic t_clear();
        sw_clr = 1;
        step(); #1;
        chk("R12 clr cause", cause, 0); chk("R12 clr epc", epc, 0);
    endtask

    task automatic t_muldiv();
        slot(0, 32'h300, 0, 1, 5'd11, 1, 1, 2, 3);
        @(negedge clk);
        chk("R8 no trap", 32'(redirect), 0); chk("R8 md go", 32'(md_go), 1);
        step(); #1;
        chk("R8 cause kept", cause, 0); chk("R8 epc kept", epc, 0);
        slot(0, 32'h304, 0, 1, 5'd6, 0, 3, 0, 4);
        @(negedge clk);
        chk("R9 stall", 32'(stall), 1); chk("R9 no wb", 32'(wb_en), 0);
        chk("R9 no trap", 32'(redirect), 0);
        step(); #1;
        chk("R9 epc kept", epc, 0);
    endtask

    task automatic t_trap_while_busy();
        slot(0, 32'h500, 0, 1, 5'd12, 0, 1, 2, 4);
        @(negedge clk);
        chk("R10 trap taken", 32'(redirect), 1);
        step(); #1;
        chk("R10 cause", cause, 32'(12) << 2);
        slot(0, 32'h504, 0, 0, 0, 0, 0, 3, 4);
        @(negedge clk);
        chk("R10 still owed", 32'(stall), 1);
        step();
        mdone = 1; mdone_rd = 5'd3;
        step();
        slot(0, 32'h508, 0, 0, 0, 0, 0, 3, 4);
        @(negedge clk);
        chk("R9 released", 32'(stall), 0); chk("R9 retires", 32'(wb_en), 1);
        step();
    endtask

    task automatic t_irq();
        irq = 1;
        @(negedge clk);
        chk("R11 no slot no irq", 32'(redirect), 0);
        step();
        irq = 1;
        slot(0, 32'h600, 0, 0, 0, 0, 1, 2, 4); slot(1, 32'h604, 0, 0, 0, 0, 1, 2, 5);
        @(negedge clk);
        chk("R11 kill", 32'(kill), 3); chk("R11 no wb", 32'(wb_en), 0);
        step(); #1;
        chk("R11 epc", epc, 32'h600); chk("R11 code", cause, 0);
    endtask

    task automatic t_eret();
        eret = 1;
        @(negedge clk);
        chk("R13 redirect", 32'(redirect), 1); chk("R13 target", rpc, 32'h600);
        step();
    endtask

    task automatic t_trap_over_clear();
        sw_clr = 1;
        slot(0, 32'h700, 0, 1, 5'd13, 0, 1, 2, 4);
        step(); #1;
        chk("R12 trap wins epc", epc, 32'h700); chk("R12 trap wins cause", cause, 32'(13) << 2);
    endtask

    initial begin
        t_reset();
        t_clean_group();
        t_young_fault();
        t_both_fault();
        t_delay_slot();
        t_clear();
        t_muldiv();
        t_trap_while_busy();
        t_irq();
        t_eret();
        t_trap_over_clear();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule